// File: doc/BRIEF.md
# Event-Driven Match Counter

The block is a single prescaled counter whose value is compared against a small bank of match registers. A table of numbered events sits on top of that comparison. Each event watches one match register, one synchronised input, or both together. An event can fire only while the current value of a software-written state register is enabled in that event's own mask. Fired events appear for one clock on an event vector. They also set sticky flags, which software clears by writing ones, and any flag whose enable bit is set raises the interrupt.

One event can be chosen as the limit. When the counter counts only upward, the limit event sends the count back to zero. When the counter counts both ways, the limit event turns the count around, and the counter climbs again once it reaches zero. Each limit action copies every reload register into its match register, so a new period or threshold takes effect at a cycle boundary.

Configuration uses a simple single-cycle register port. Writes happen on `wr_en`, and reads are combinational from `addr`. Addresses are grouped four to a block: general control (0 to 3), match values (4 to 7), reload values (8 to 11), event control (12 to 15) and event state masks (16 to 19).

Top module: `evt_match_timer`

## Requirements
- R1: The count advances by one on every prescaled tick. A tick occurs once every P+1 clocks, where P is bits [7:4] of the control register at address 0. P = 0 gives a tick on every clock.
- R2: Control bit 0 (halt, reset value 1) stops ticking and freezes the count. Writing the control register with bit 1 (clear) set zeroes the count, the prescale phase and the direction. If halt is also set, the count stays at 0 until halt is cleared. After reset the count, events, interrupt and direction are all 0, and the control register reads 0x0001.
- R3: Bits [1:0] of event e's control register (address 12+e) select the combine mode. Value 1 fires on a match alone. Value 2 fires on an input edge alone. Values 0 and 3 need a match and an input edge in the same clock.
- R4: Bits [5:4] of an event's control register select its match register (match m sits at address 4+m). Bits [9:8] select its input. Edges on inputs that are not selected do not fire the event.
- R5: Event e can fire only when bit s of its mask register (address 16+e) is set, where s is the value of the state register at address 1.
- R6: Control bit 8 enables the limit, and bits [13:12] select the limit event. With control bit 2 at 0 (up-only), the limit event firing on a tick makes the next count 0.
- R7: With control bit 2 at 1 (up/down), the limit event firing on a tick while counting up reverses the counter: the count steps down and `dir_o` becomes 1. A tick at count 0 while counting down sets `dir_o` back to 0 and makes the count 1.
- R8: Every limit action copies reload register m (address 8+m) into match register m. A match register reads back its current value.
- R9: Events set the matching bits of the flag register (address 2). Writing ones to that register clears those bits and leaves the other bits alone. `irq_o` is high exactly when a set flag has its bit set in the interrupt-enable register (address 3).
- R10: A match condition lasts one clock, on the tick at which the count equals the selected match value. This holds even when one count value spans several clocks.
- R11: An input-only event is asserted for one clock, during the second clock after the selected input rises. The input passes through two synchroniser flops before its edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for write and read |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data (combinational) |
| io_i | input | 4 | Asynchronous event inputs |
| evt_o | output | 4 | One-clock event pulses |
| irq_o | output | 1 | Interrupt: enabled flag pending |
| count_o | output | 16 | Current counter value |
| dir_o | output | 1 | 1 while counting down |

## Verification
Assertions check, on every clock, these rules:
- the prescaled tick is spaced out;
- the count holds when there is no tick, zeroes on clear, and wraps to zero at an up-only limit;
- turnarounds in up/down mode follow the rules above;
- no event fires outside its state mask;
- flags stay set until a write clears them;
- each limit action loads every reload value.

Only the bench scenarios can show the end-to-end behaviour. That covers the measured period for each prescale, limit and direction combination, and the synchroniser latency. It also covers each combine mode and select field firing or staying quiet, and a reloaded limit changing the next period.

// File: rtl/emt_pkg.sv
package emt_pkg;

    localparam int CNT_W   = 16;
    localparam int PRE_W   = 4;
    localparam int N_EVT   = 4;
    localparam int N_MATCH = 4;
    localparam int N_IO    = 4;
    localparam int N_STATE = 4;
    localparam int DATA_W  = CNT_W;

    localparam int MSEL_W  = $clog2(N_MATCH);
    localparam int IOSEL_W = $clog2(N_IO);
    localparam int ESEL_W  = $clog2(N_EVT);
    localparam int STATE_W = $clog2(N_STATE);
    localparam int N_MAX   = (N_EVT > N_MATCH) ? N_EVT : N_MATCH;
    localparam int IDX_W   = (N_MAX > 4) ? $clog2(N_MAX) : 2;
    localparam int ADDR_W  = IDX_W + 3;

    // control register bit positions
    localparam int CB_HALT   = 0;
    localparam int CB_CLR    = 1;
    localparam int CB_BIDIR  = 2;
    localparam int CB_PRE    = 4;
    localparam int CB_LIMEN  = 8;
    localparam int CB_LIMSEL = 12;

    // event control bit positions
    localparam int EB_COMB  = 0;
    localparam int EB_MSEL  = 4;
    localparam int EB_IOSEL = 8;

    typedef enum logic [2:0] {
        G_MISC   = 3'd0,
        G_MATCH  = 3'd1,
        G_RELOAD = 3'd2,
        G_EVCTL  = 3'd3,
        G_EVMASK = 3'd4
    } grp_e;

    typedef enum logic [1:0] {
        CMB_BOTH     = 2'd0,
        CMB_MATCH    = 2'd1,
        CMB_IO       = 2'd2,
        CMB_BOTH_ALT = 2'd3
    } combine_e;

    typedef struct packed {
        combine_e             comb;
        logic [MSEL_W-1:0]    msel;
        logic [IOSEL_W-1:0]   iosel;
    } evcfg_t;

    typedef struct packed {
        logic                 halt;
        logic                 bidir;
        logic [PRE_W-1:0]     prescale;
        logic                 lim_en;
        logic [ESEL_W-1:0]    lim_sel;
    } ctrl_t;

    function automatic evcfg_t unpack_evcfg(input logic [DATA_W-1:0] d);
        evcfg_t c;
        c.comb  = combine_e'(d[EB_COMB +: 2]);
        c.msel  = d[EB_MSEL +: MSEL_W];
        c.iosel = d[EB_IOSEL +: IOSEL_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_evcfg(input evcfg_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[EB_COMB +: 2]        = c.comb;
        d[EB_MSEL +: MSEL_W]   = c.msel;
        d[EB_IOSEL +: IOSEL_W] = c.iosel;
        return d;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.halt     = d[CB_HALT];
        c.bidir    = d[CB_BIDIR];
        c.prescale = d[CB_PRE +: PRE_W];
        c.lim_en   = d[CB_LIMEN];
        c.lim_sel  = d[CB_LIMSEL +: ESEL_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[CB_HALT]              = c.halt;
        d[CB_BIDIR]             = c.bidir;
        d[CB_PRE +: PRE_W]      = c.prescale;
        d[CB_LIMEN]             = c.lim_en;
        d[CB_LIMSEL +: ESEL_W]  = c.lim_sel;
        return d;
    endfunction

endpackage

// File: rtl/emt_prescale.sv
module emt_prescale
    import emt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;

    assign tick = run && (phase_q >= div);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && div != '0) |=> (!tick || div == '0)); // R1

endmodule

// File: rtl/emt_edge_sync.sv
module emt_edge_sync
    import emt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IO-1:0] din,
    output logic [N_IO-1:0] rise
);

    for (genvar gi = 0; gi < N_IO; gi++) begin : g_bit
        logic [2:0] sh_q;   // [0],[1] synchronizer, [2] history
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[1:0], din[gi]};
        end
        assign rise[gi] = sh_q[1] & ~sh_q[2];
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0)); // R11

endmodule

// File: rtl/emt_event_slot.sv
module emt_event_slot
    import emt_pkg::*;
(
    input  evcfg_t                          cfg,
    input  logic                            armed,
    input  logic                            tick,
    input  logic [CNT_W-1:0]                count,
    input  logic [N_MATCH-1:0][CNT_W-1:0]   match_bank,
    input  logic [N_IO-1:0]                 rise,
    output logic                            fire
);

    logic hit_m;
    logic hit_io;

    always_comb begin
        hit_m  = tick && (count == match_bank[cfg.msel]);
        hit_io = rise[cfg.iosel];
        case (cfg.comb)
            CMB_MATCH: fire = armed && hit_m;
            CMB_IO:    fire = armed && hit_io;
            default:   fire = armed && hit_m && hit_io;
        endcase
    end

endmodule

// File: rtl/emt_counter.sv
module emt_counter
    import emt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             bidir,
    input  logic             limit_fire,
    output logic [CNT_W-1:0] count,
    output logic             down,
    output logic             lim_act
);

    assign lim_act = tick && !clr && limit_fire && (!bidir || !down);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            down  <= 1'b0;
        end else if (tick) begin
            if (!bidir) begin
                down  <= 1'b0;
                count <= limit_fire ? '0 : count + 1'b1;
            end else if (down) begin
                if (count == '0) begin
                    down  <= 1'b0;
                    count <= CNT_W'(1);
                end else begin
                    count <= count - 1'b1;
                end
            end else if (limit_fire) begin
                down  <= 1'b1;
                count <= count - 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(count)); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !down)); // R2
    AST_UP_LIMIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && !bidir && limit_fire) |=> (count == '0)); // R6
    AST_TURN_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && bidir && !down && limit_fire) |=> down); // R7
    AST_TURN_UP: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && bidir && down && count == '0) |=> (!down && count == CNT_W'(1))); // R7

endmodule

// File: rtl/evt_match_timer.sv
module evt_match_timer
    import emt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_IO-1:0]   io_i,
    output logic [N_EVT-1:0]  evt_o,
    output logic              irq_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              dir_o
);

    ctrl_t                              ctrl_q;
    logic [STATE_W-1:0]                 state_q;
    logic [N_EVT-1:0]                   flags_q;
    logic [N_EVT-1:0]                   inten_q;
    logic [N_MATCH-1:0][CNT_W-1:0]      match_q;
    logic [N_MATCH-1:0][CNT_W-1:0]      reload_q;
    evcfg_t [N_EVT-1:0]                 evcfg_q;
    logic [N_EVT-1:0][N_STATE-1:0]      evmask_q;

    grp_e                               grp;
    logic [IDX_W-1:0]                   idx;
    logic                               wr_misc;
    logic                               clr_pulse;
    logic [N_EVT-1:0]                   w1c;
    logic [N_EVT-1:0]                   armed;
    logic [N_EVT-1:0]                   fire;
    logic [N_IO-1:0]                    rise;
    logic                               tick;
    logic                               limit_fire;
    logic                               lim_act;
    logic [CNT_W-1:0]                   count;
    logic                               down;

    assign grp       = grp_e'(addr[ADDR_W-1:IDX_W]);
    assign idx       = addr[IDX_W-1:0];
    assign wr_misc   = wr_en && (grp == G_MISC);
    assign clr_pulse = wr_misc && (idx == IDX_W'(0)) && wr_data[CB_CLR];
    assign w1c       = (wr_misc && idx == IDX_W'(2)) ? wr_data[N_EVT-1:0] : '0;

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= unpack_ctrl(DATA_W'(1));
            state_q  <= '0;
            inten_q  <= '0;
            flags_q  <= '0;
            match_q  <= '0;
            reload_q <= '0;
            evcfg_q  <= '0;
            evmask_q <= '0;
        end else begin
            flags_q <= (flags_q & ~w1c) | fire;
            if (wr_misc && idx == IDX_W'(0)) ctrl_q  <= unpack_ctrl(wr_data);
            if (wr_misc && idx == IDX_W'(1)) state_q <= wr_data[STATE_W-1:0];
            if (wr_misc && idx == IDX_W'(3)) inten_q <= wr_data[N_EVT-1:0];
            for (int m = 0; m < N_MATCH; m++) begin
                if (wr_en && grp == G_MATCH && idx == IDX_W'(m)) begin
                    match_q[m] <= wr_data[CNT_W-1:0];
                end else if (lim_act) begin
                    match_q[m] <= reload_q[m];
                end
                if (wr_en && grp == G_RELOAD && idx == IDX_W'(m)) begin
                    reload_q[m] <= wr_data[CNT_W-1:0];
                end
            end
            for (int e = 0; e < N_EVT; e++) begin
                if (wr_en && grp == G_EVCTL && idx == IDX_W'(e)) begin
                    evcfg_q[e] <= unpack_evcfg(wr_data);
                end
                if (wr_en && grp == G_EVMASK && idx == IDX_W'(e)) begin
                    evmask_q[e] <= wr_data[N_STATE-1:0];
                end
            end
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_data = '0;
        case (grp)
            G_MISC: begin
                case (idx)
                    IDX_W'(0): rd_data = pack_ctrl(ctrl_q);
                    IDX_W'(1): rd_data = DATA_W'(state_q);
                    IDX_W'(2): rd_data = DATA_W'(flags_q);
                    default:   rd_data = DATA_W'(inten_q);
                endcase
            end
            G_MATCH:  rd_data = DATA_W'(match_q[idx]);
            G_RELOAD: rd_data = DATA_W'(reload_q[idx]);
            G_EVCTL:  rd_data = pack_evcfg(evcfg_q[idx]);
            G_EVMASK: rd_data = DATA_W'(evmask_q[idx]);
            default:  rd_data = '0;
        endcase
    end

    // ---------------- datapath ----------------
    emt_prescale u_prescale (
        .clk  (clk),
        .rst  (rst),
        .run  (!ctrl_q.halt),
        .clr  (clr_pulse),
        .div  (ctrl_q.prescale),
        .tick (tick)
    );

    emt_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (io_i),
        .rise (rise)
    );

    for (genvar ge = 0; ge < N_EVT; ge++) begin : g_evt
        assign armed[ge] = evmask_q[ge][state_q];
        emt_event_slot u_slot (
            .cfg        (evcfg_q[ge]),
            .armed      (armed[ge]),
            .tick       (tick),
            .count      (count),
            .match_bank (match_q),
            .rise       (rise),
            .fire       (fire[ge])
        );
    end

    assign limit_fire = ctrl_q.lim_en && fire[ctrl_q.lim_sel];

    emt_counter u_counter (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_pulse),
        .tick       (tick),
        .bidir      (ctrl_q.bidir),
        .limit_fire (limit_fire),
        .count      (count),
        .down       (down),
        .lim_act    (lim_act)
    );

    assign evt_o   = fire;
    assign irq_o   = |(flags_q & inten_q);
    assign count_o = count;
    assign dir_o   = down;

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
        ((fire & ~armed) == '0)); // R5
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (fire != '0) |=> ((flags_q & $past(fire)) == $past(fire))); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(flags_q & ~w1c)) == $past(flags_q & ~w1c))); // R9
    AST_RELOAD_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (lim_act && !wr_en) |=> (match_q == $past(reload_q))); // R8

endmodule

// File: tb/evt_match_timer_bench.sv
`timescale 1ns/1ps
module evt_match_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  io_i = '0;
    logic [3:0]  evt_o;
    logic        irq_o;
    logic [15:0] count_o;
    logic        dir_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    evt_match_timer u_evt_match_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .io_i(io_i), .evt_o(evt_o), .irq_o(irq_o),
        .count_o(count_o), .dir_o(dir_o)
    );

    // {prescale, limit, bidir, expected period in clocks}
    localparam int TBL [5][4] = '{
        '{0, 5, 0, 6},
        '{2, 4, 0, 15},
        '{1, 3, 1, 12},
        '{0, 7, 1, 14},
        '{3, 2, 0, 12}
    };

    function automatic logic [15:0] ctrlw(input bit halt, input bit clr, input bit bidir,
                                          input int pre, input bit limen, input int limsel);
        logic [15:0] d;
        d = '0;
        d[0] = halt; d[1] = clr; d[2] = bidir;
        d[7:4] = pre[3:0]; d[8] = limen; d[13:12] = limsel[1:0];
        return d;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[4:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdreg(input int a, output logic [15:0] v);
        addr = a[4:0];
        #1;
        v = rd_data;
    endtask

    task automatic wait_evt(input int e, input int maxc, output bit found);
        found = 1'b0;
        for (int n = 0; n < maxc && !found; n++) begin
            @(negedge clk);
            if (evt_o[e]) found = 1'b1;
        end
    endtask

    task automatic measure(input int e, output int per);
        bit f;
        int n;
        per = -1;
        wait_evt(e, 2000, f);
        if (f) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!evt_o[e] && n < 2000);
            if (evt_o[e]) per = n;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c;
        int p;
        bit f;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R2 reset count", count_o, 0);
        chk("R2 reset events", evt_o, 0);
        chk("R9 reset irq", irq_o, 0);
        chk("R7 reset dir", dir_o, 0);
        rdreg(0, v);
        chk("R2 reset ctrl", v, 16'h0001);

        // table walk: period per prescale / limit / direction
        for (int i = 0; i < 5; i++) begin
            wr(0, ctrlw(1, 1, TBL[i][2] != 0, TBL[i][0], 1, 0));
            wr(4, TBL[i][1]);
            wr(8, TBL[i][1]);
            wr(12, 1);
            wr(16, 1);
            wr(0, ctrlw(0, 0, TBL[i][2] != 0, TBL[i][0], 1, 0));
            measure(0, p);
            chk("R1 R6 R7 period table", p, TBL[i][3]);
        end

        // halt with clear holds zero
        wr(0, ctrlw(1, 1, 0, 0, 0, 0));
        chk("R2 clear zero", count_o, 0);
        repeat (10) @(negedge clk);
        chk("R2 halt holds zero", count_o, 0);
        // halt alone freezes
        wr(0, ctrlw(0, 0, 0, 0, 0, 0));
        repeat (7) @(negedge clk);
        wr(0, ctrlw(1, 0, 0, 0, 0, 0));
        c = count_o;
        repeat (5) @(negedge clk);
        chk("R2 halt freezes", count_o, c);
        chk("R2 halt nonzero", count_o != 0, 1);

        // prescale 3: exactly two ticks in eight clocks
        wr(0, ctrlw(1, 1, 0, 3, 0, 0));
        wr(0, ctrlw(0, 0, 0, 3, 0, 0));
        repeat (3) @(negedge clk);
        c = count_o;
        repeat (8) @(negedge clk);
        chk("R1 prescale rate", count_o, c + 16'd2);
        wr(0, ctrlw(1, 1, 0, 0, 0, 0));

        // input-only event and synchronizer latency
        wr(2, 'hF);
        wr(13, 'h202);        // event1: comb 2, input 2
        wr(17, 1);
        @(negedge clk); io_i[2] = 1'b1;
        @(negedge clk); chk("R11 first clock", evt_o[1], 0);
        @(negedge clk); chk("R11 second clock", evt_o[1], 1);
        @(negedge clk); chk("R11 one clock", evt_o[1], 0);
        rdreg(2, v);
        chk("R9 flag set", v[1], 1);
        wr(2, 'hF);
        rdreg(2, v);
        chk("R9 flag cleared", v[1], 0);
        io_i[1] = 1'b1;
        repeat (5) @(negedge clk);
        rdreg(2, v);
        chk("R4 other input ignored", v[1], 0);

        // combined mode on event2: match 1, input 0
        wr(5, 5);
        wr(14, 'h010);
        wr(18, 1);
        io_i[0] = 1'b1;
        repeat (5) @(negedge clk);
        rdreg(2, v);
        chk("R3 edge alone", v[2], 0);
        wr(0, ctrlw(0, 0, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        wr(0, ctrlw(1, 1, 0, 0, 0, 0));
        rdreg(2, v);
        chk("R3 match alone", v[2], 0);
        io_i[0] = 1'b0;
        repeat (4) @(negedge clk);
        wr(5, 2);
        wr(0, ctrlw(0, 0, 0, 0, 0, 0));
        io_i[0] = 1'b1;
        repeat (6) @(negedge clk);
        wr(0, ctrlw(1, 1, 0, 0, 0, 0));
        rdreg(2, v);
        chk("R3 match and edge", v[2], 1);

        // state mask on event3: match only, match register 2
        wr(2, 'hF);
        wr(6, 3);
        wr(15, 'h021);
        wr(19, 'h2);
        wr(0, ctrlw(0, 0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        wr(0, ctrlw(1, 1, 0, 0, 0, 0));
        rdreg(2, v);
        chk("R5 masked state", v[3], 0);
        wr(1, 1);
        wr(0, ctrlw(0, 0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        wr(0, ctrlw(1, 1, 0, 0, 0, 0));
        rdreg(2, v);
        chk("R5 R4 enabled state", v[3], 1);

        // interrupt and write-one-to-clear
        chk("R9 irq disabled", irq_o, 0);
        wr(3, 'h8);
        chk("R9 irq enabled", irq_o, 1);
        wr(2, 'h4);
        rdreg(2, v);
        chk("R9 other flag kept", v[3], 1);
        chk("R9 irq kept", irq_o, 1);
        wr(2, 'h8);
        chk("R9 irq cleared", irq_o, 0);
        wr(3, 0);
        wr(1, 0);

        // one-clock match pulse and up-only wrap with prescale 3
        wr(0, ctrlw(1, 1, 0, 3, 1, 0));
        wr(4, 5);
        wr(8, 5);
        wr(0, ctrlw(0, 0, 0, 3, 1, 0));
        wait_evt(0, 200, f);
        chk("R10 pulse seen", f, 1);
        chk("R10 count at match", count_o, 5);
        @(negedge clk);
        chk("R10 pulse one clock", evt_o[0], 0);
        chk("R6 wrap to zero", count_o, 0);

        // reload takes effect at limit
        wr(0, ctrlw(1, 1, 0, 0, 1, 0));
        wr(4, 4);
        wr(8, 9);
        wr(0, ctrlw(0, 0, 0, 0, 1, 0));
        measure(0, p);
        chk("R8 reloaded period", p, 10);
        rdreg(4, v);
        chk("R8 match readback", v, 9);

        // up/down turnarounds
        wr(0, ctrlw(1, 1, 1, 1, 1, 0));
        wr(4, 3);
        wr(8, 3);
        wr(0, ctrlw(0, 0, 1, 1, 1, 0));
        wait_evt(0, 200, f);
        chk("R7 up at limit", dir_o, 0);
        @(negedge clk);
        chk("R7 dir down", dir_o, 1);
        chk("R7 count after turn", count_o, 2);
        f = 1'b0;
        for (int n = 0; n < 50 && !f; n++) begin
            @(negedge clk);
            if (!dir_o) f = 1'b1;
        end
        chk("R7 turned up", f, 1);
        chk("R7 count after zero", count_o, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule